// File: doc/BRIEF.md
# FIFO-Driven DMA Request Generator

This block turns the fill state of a serial port's receive and transmit FIFOs into DMA request lines. Each direction drives two requests: a single-transfer request that asks for one item to be moved, and a burst request that asks for a block of items to be moved once enough data (receive) or enough free space (transmit) has built up. The burst threshold of each direction is chosen by a 3-bit code that selects a fraction of the FIFO depth. The depth is supplied as an input, so one instance serves FIFOs of different configured sizes. A depth of one is allowed, which is the case where the FIFOs are switched off.

Each direction has its own enable. While a direction is disabled, both of its requests stay low. The two directions never affect each other. All four requests are registered, so each one reflects the inputs sampled at the previous rising clock edge. The reset input is asynchronous and active low. It is released inside the block through a two-stage synchronizer.

Top module: `xfer_req_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge that samples an enable, all four request outputs are low.
- R2: The receive single request is high exactly when the receive enable is high and the receive count is at least 1.
- R3: The receive burst request is high exactly when the receive enable is high and the receive count is greater than or equal to the receive threshold.
- R4: The transmit single request is high exactly when the transmit enable is high and the transmit count is below the FIFO depth.
- R5: The transmit burst request is high exactly when the transmit enable is high and the transmit count is strictly below the transmit threshold.
- R6: A low enable forces both requests of its own direction low, whatever the counts. The other direction's requests are unaffected.
- R7: Threshold code values select these thresholds: 0 gives floor(depth×1/8), 1 gives floor(depth×2/8), 2 gives floor(depth×4/8), 3 gives floor(depth×6/8) and 4 gives floor(depth×7/8). Codes 5, 6 and 7 behave as code 2. A threshold that computes to 0 is raised to 1.
- R8: Every request output is registered. It changes only at a rising clock edge and shows the inputs sampled at that edge.
- R9: A burst request is never high unless the single request of the same direction is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_depth_i | input | 6 | Configured FIFO depth, 1 to MAX_DEPTH |
| rx_count_i | input | 6 | Entries held in the receive FIFO |
| tx_count_i | input | 6 | Entries held in the transmit FIFO |
| rx_lvl_i | input | 3 | Receive threshold code (R7) |
| tx_lvl_i | input | 3 | Transmit threshold code (R7) |
| rx_en_i | input | 1 | Receive direction DMA enable |
| tx_en_i | input | 1 | Transmit direction DMA enable |
| rx_single_o | output | 1 | Receive single-transfer request |
| rx_burst_o | output | 1 | Receive burst request |
| tx_single_o | output | 1 | Transmit single-transfer request |
| tx_burst_o | output | 1 | Transmit burst request |

## Verification
The assertions take for granted that the configured depth is between 1 and MAX_DEPTH and that neither FIFO count exceeds it. The burst-implies-single property (R9) and the full-FIFO checks depend on these limits, and an input check states them explicitly. The stimulus keeps within these limits by drawing the depth first and then drawing each count between zero and that depth. The directed cases place counts exactly at zero, at the threshold and one either side of it, and at the depth. They also cover a depth of one and the reserved threshold codes.

// File: rtl/xfer_req_pkg.sv
package xfer_req_pkg;
  typedef enum logic [2:0] {
    LVL_EIGHTH   = 3'd0,
    LVL_QUARTER  = 3'd1,
    LVL_HALF     = 3'd2,
    LVL_3QUARTER = 3'd3,
    LVL_7EIGHTH  = 3'd4
  } lvl_code_e;

  localparam int unsigned LVL_FRAC_SHIFT = 3;

  function automatic logic [2:0] lvl_mult(input logic [2:0] code);
    logic [2:0] m;
    case (code)
      LVL_EIGHTH:   m = 3'd1;
      LVL_QUARTER:  m = 3'd2;
      LVL_HALF:     m = 3'd4;
      LVL_3QUARTER: m = 3'd6;
      LVL_7EIGHTH:  m = 3'd7;
      default:      m = 3'd4;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xfer_lvl_decode.sv
module xfer_lvl_decode
  import xfer_req_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic [CNT_W-1:0] depth_i,
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] thr_o
);
  localparam int unsigned PROD_W = CNT_W + 3;

  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  frac;

  always_comb begin
    prod  = PROD_W'(depth_i) * PROD_W'(lvl_mult(code_i));
    frac  = CNT_W'(prod >> LVL_FRAC_SHIFT);
    thr_o = (frac == '0) ? CNT_W'(1) : frac;
  end

  // R7: the threshold is never zero and never above the depth
  always_comb begin
    if (depth_i != '0) begin
      assert_thr_in_range_R7: assert (thr_o != '0 && thr_o <= depth_i)
        else $error("threshold %0d out of range for depth %0d", thr_o, depth_i);
    end
  end
endmodule

// File: rtl/xfer_req_chan.sv
module xfer_req_chan #(
  parameter int unsigned CNT_W = 6,
  parameter bit          IS_TX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] depth_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             single_o,
  output logic             burst_o
);
  logic single_d, burst_d;
  logic single_q, burst_q;
  logic upd_en;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        single_d = en_i && (count_i < depth_i);
        burst_d  = en_i && (count_i < thr_i);
      end
    end else begin : g_rx
      always_comb begin
        single_d = en_i && (count_i != '0);
        burst_d  = en_i && (count_i >= thr_i);
      end
    end
  endgenerate

  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q <= 1'b0;
      burst_q  <= 1'b0;
    end else if (upd_en) begin
      single_q <= single_d;
      burst_q  <= burst_d;
    end
  end

  assign single_o = single_q;
  assign burst_o  = burst_q;

  // R6: a disabled channel raises nothing in the following cycle
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> (!single_o && !burst_o));

  // R9: burst only together with single
  assert_burst_has_single_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    burst_o |-> single_o);

  generate
    if (IS_TX) begin : g_tx_chk
      // R4: a full transmit FIFO never asks for a single transfer
      assert_full_no_single_R4: assert property (@(posedge clk) disable iff (!rst_ni)
        (count_i == depth_i) |=> !single_o);
      // R5: an enabled, empty transmit FIFO asks for a burst
      assert_empty_burst_R5: assert property (@(posedge clk) disable iff (!rst_ni)
        (en_i && count_i == '0) |=> burst_o);
    end else begin : g_rx_chk
      // R2: an empty receive FIFO never asks for a single transfer
      assert_empty_no_single_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        (count_i == '0) |=> !single_o);
      // R3: an enabled, full receive FIFO asks for a burst
      assert_full_burst_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        (en_i && count_i == depth_i && depth_i != '0) |=> burst_o);
    end
  endgenerate

  // R8: outputs move only when the sampled request value differs
  assert_reg_follow_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $stable(single_d) |=> $stable(single_o) || (single_o == $past(single_d)));
endmodule

// File: rtl/xfer_req_gen.sv
module xfer_req_gen #(
  parameter int unsigned MAX_DEPTH = 32,
  localparam int unsigned CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_depth_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [2:0]       rx_lvl_i,
  input  logic [2:0]       tx_lvl_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  output logic             rx_single_o,
  output logic             rx_burst_o,
  output logic             tx_single_o,
  output logic             tx_burst_o
);
  localparam int unsigned N_CH = 2;

  logic             rst_sync_n;
  logic [CNT_W-1:0] ch_count [N_CH];
  logic [2:0]       ch_lvl   [N_CH];
  logic             ch_en    [N_CH];
  logic [CNT_W-1:0] ch_thr   [N_CH];
  logic             ch_single[N_CH];
  logic             ch_burst [N_CH];

  xfer_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ch_count[0] = rx_count_i;
    ch_count[1] = tx_count_i;
    ch_lvl[0]   = rx_lvl_i;
    ch_lvl[1]   = tx_lvl_i;
    ch_en[0]    = rx_en_i;
    ch_en[1]    = tx_en_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    xfer_lvl_decode #(.CNT_W(CNT_W)) u_lvl (
      .depth_i (fifo_depth_i),
      .code_i  (ch_lvl[c]),
      .thr_o   (ch_thr[c])
    );
    xfer_req_chan #(.CNT_W(CNT_W), .IS_TX(c == 1)) u_chan (
      .clk      (clk),
      .rst_ni   (rst_sync_n),
      .en_i     (ch_en[c]),
      .count_i  (ch_count[c]),
      .depth_i  (fifo_depth_i),
      .thr_i    (ch_thr[c]),
      .single_o (ch_single[c]),
      .burst_o  (ch_burst[c])
    );
  end

  assign rx_single_o = ch_single[0];
  assign rx_burst_o  = ch_burst[0];
  assign tx_single_o = ch_single[1];
  assign tx_burst_o  = ch_burst[1];

  // R9 input limits: depth in range, counts never above depth
  assert_inputs_in_range_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fifo_depth_i != '0) && (fifo_depth_i <= CNT_W'(MAX_DEPTH)) &&
    (rx_count_i <= fifo_depth_i) && (tx_count_i <= fifo_depth_i));

  // R1: nothing requested while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> !(rx_single_o || rx_burst_o || tx_single_o || tx_burst_o));
endmodule

// File: tb/xfer_req_gen_tb.sv
`timescale 1ns/1ps
module xfer_req_gen_tb;
  localparam int MAXD = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] depth = 6'd16;
  logic [5:0] rxc = '0, txc = '0;
  logic [2:0] rxl = '0, txl = '0;
  logic       rxe = 1'b0, txe = 1'b0;
  logic       rx_s, rx_b, tx_s, tx_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit p_rs = 0, p_rb = 0, p_ts = 0, p_tb = 0;

  always #2.5 clk = ~clk;

  xfer_req_gen #(.MAX_DEPTH(MAXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_depth_i(depth),
    .rx_count_i(rxc), .tx_count_i(txc), .rx_lvl_i(rxl), .tx_lvl_i(txl),
    .rx_en_i(rxe), .tx_en_i(txe),
    .rx_single_o(rx_s), .rx_burst_o(rx_b), .tx_single_o(tx_s), .tx_burst_o(tx_b)
  );

  function automatic int thr(int d, int code);
    int m, t;
    case (code)
      0: m = 1; 1: m = 2; 2: m = 4; 3: m = 6; 4: m = 7;
      default: m = 4;
    endcase
    t = (d * m) / 8;
    if (t == 0) t = 1;
    return t;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (depth=%0d rxc=%0d txc=%0d rxl=%0d txl=%0d rxe=%0b txe=%0b)",
               tag, act, exp, depth, rxc, txc, rxl, txl, rxe, txe);
    end
  endtask

  task automatic apply(input int d, input int rc, input int tc,
                       input int rl, input int tl, input bit re, input bit te);
    bit e_rs, e_rb, e_ts, e_tb;
    @(negedge clk);
    depth = 6'(d); rxc = 6'(rc); txc = 6'(tc);
    rxl = 3'(rl); txl = 3'(tl); rxe = re; txe = te;
    #1;
    // R8: no change before the next rising edge
    chk(rx_s, p_rs, "R8 rx_single held");
    chk(tx_b, p_tb, "R8 tx_burst held");
    e_rs = re && (rc >= 1);
    e_rb = re && (rc >= thr(d, rl));
    e_ts = te && (tc < d);
    e_tb = te && (tc < thr(d, tl));
    @(negedge clk);
    chk(rx_s, e_rs, "R2 rx_single");
    chk(rx_b, e_rb, "R3/R7 rx_burst");
    chk(tx_s, e_ts, "R4 tx_single");
    chk(tx_b, e_tb, "R5/R7 tx_burst");
    if (!re) chk(rx_s | rx_b, 1'b0, "R6 rx disabled");
    if (!te) chk(tx_s | tx_b, 1'b0, "R6 tx disabled");
    chk(!(rx_b && !rx_s) && !(tx_b && !tx_s), 1'b1, "R9 burst implies single");
    p_rs = e_rs; p_rb = e_rb; p_ts = e_ts; p_tb = e_tb;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset with inputs that would otherwise request
    depth = 6'd16; rxc = 6'd16; txc = 6'd0; rxe = 1'b1; txe = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_s | rx_b | tx_s | tx_b, 1'b0, "R1 reset quiet");
    rxe = 1'b0; txe = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_s | rx_b | tx_s | tx_b, 1'b0, "R1 after release, disabled");

    // Directed: thresholds around depth 16, code 2 gives 8
    apply(16, 7, 9, 2, 2, 1, 1);
    apply(16, 8, 8, 2, 2, 1, 1);
    apply(16, 9, 7, 2, 2, 1, 1);
    apply(16, 0, 16, 0, 0, 1, 1);
    apply(16, 16, 0, 4, 4, 1, 1);
    apply(16, 14, 13, 4, 4, 1, 1);
    // R7 reserved codes act as half
    apply(16, 8, 7, 5, 6, 1, 1);
    apply(16, 7, 8, 7, 7, 1, 1);
    // R7 depth one: threshold raised to one
    apply(1, 1, 0, 0, 0, 1, 1);
    apply(1, 0, 1, 4, 4, 1, 1);
    // R6 one direction disabled, the other unaffected
    apply(16, 16, 0, 0, 0, 0, 1);
    apply(16, 16, 0, 0, 0, 1, 0);
    apply(32, 28, 27, 3, 3, 1, 1);
    apply(32, 32, 32, 1, 1, 1, 1);

    // Random stimulus within the input limits
    for (int i = 0; i < 3000; i++) begin
      int d;
      d = 1 + int'($urandom_range(MAXD - 1, 0));
      apply(d, int'($urandom_range(d, 0)), int'($urandom_range(d, 0)),
            int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
            ($urandom_range(3, 0) != 0), ($urandom_range(3, 0) != 0));
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule